// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Logic

Several peripheral interfaces share a single interrupt request line toward the processor. Each interface, or slot, can hold one pending request. The shared line is the OR of all pending bits.

When the processor sees the line high, it sends a one-cycle acknowledge pulse. The pulse enters slot 0 and travels along the chain in index order. The first slot that has a request pending stops the pulse and services it. That slot's pending bit clears, and its programmed vector is returned to the processor. Slots later in the chain never see the pulse. Priority therefore comes only from position: slot 0 is highest.

Each slot's vector comes from a register loaded by a configuration write. If the pulse passes through the whole chain without finding a pending slot, the block returns an all-zero vector and raises a no-source flag.

Top module: `intr_chain_top`

## Requirements
- R1: After a synchronous active-low reset, no slot is pending. `irq_line`, `vec_valid` and `no_source` are low, `vec_out` is zero, and every vector register holds zero.
- R2: A high bit `src_req[i]` at a clock edge makes slot i pending. `irq_line` is high from that edge onward while any slot is pending, and low once none is.
- R3: An `ack_pulse` sampled at edge t raises `vec_valid` for exactly the cycle after edge t. In that cycle `vec_out` carries the vector of the pending slot with the lowest index.
- R4: The serviced slot's pending bit clears at the acknowledge edge, and all other pending slots stay pending. A later acknowledge therefore services the next pending slot in index order.
- R5: An acknowledge that finds no slot pending gives `vec_valid`=1, `no_source`=1 and `vec_out`=0 in the following cycle. When a slot is serviced, `no_source` is 0.
- R6: Whenever `vec_valid` is low, `vec_out` is zero and `no_source` is low.
- R7: A cycle with `cfg_we`=1 loads `cfg_vec` into the vector register of slot `cfg_idx`. A `cfg_idx` value of N_SRC or more changes no vector register.
- R8: If `src_req[i]` is high at the same edge at which slot i is serviced, the vector is still returned, and slot i stays pending (the new request wins over the clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | N_SRC | Per-slot request set, sampled at each edge |
| cfg_we | input | 1 | Vector register write enable |
| cfg_idx | input | $clog2(N_SRC)+1 | Slot index for the write |
| cfg_vec | input | VEC_W | Vector value to write |
| ack_pulse | input | 1 | One-cycle interrupt acknowledge from the processor |
| irq_line | output | 1 | Shared request line, OR of all pending bits |
| vec_out | output | VEC_W | Vector of the serviced slot, zero otherwise |
| vec_valid | output | 1 | `vec_out` and `no_source` are valid this cycle |
| no_source | output | 1 | The acknowledge found no pending slot |

## Verification
Every result is one register stage from its cause. A request set at edge t shows on `irq_line` right after edge t. An acknowledge sampled at edge t makes `vec_valid`, `vec_out` and `no_source` valid for the one cycle after edge t, and `vec_valid` is low again after edge t+1. The bench drives on falling edges and reads on the next falling edge, which is half a period after the edge that produced the result. It checks the response in that cycle, then checks one cycle later that the strobe has dropped and `vec_out` has returned to zero.

// File: rtl/intr_chain_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the interrupt acknowledge chain.
// Assumes: slot count of at least 2.
package intr_chain_pkg;

    // Width of the slot index: one spare bit so out-of-range writes can be expressed.
    function automatic int unsigned slot_idx_width(input int unsigned n_slots);
        return $clog2(n_slots) + 1;
    endfunction

endpackage

// File: rtl/intr_chain_cell.sv
`timescale 1ns/1ps
// One slot of the acknowledge chain: holds the pending bit and the vector register.
// It absorbs the incoming acknowledge when pending and passes it on otherwise.
// Assumes: ack_in is a combinational ripple that is valid within the same cycle.
module intr_chain_cell #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_set,
    input  logic             cfg_load,
    input  logic [VEC_W-1:0] cfg_vec,
    input  logic             ack_in,
    output logic             ack_out,
    output logic             grant,
    output logic             pending,
    output logic [VEC_W-1:0] vec_q
);

    // Absorb the acknowledge when pending; pass it downstream otherwise.
    always_comb begin
        grant   = ack_in & pending;
        ack_out = ack_in & ~pending;
    end

    // Pending bit: a new request has priority over the clear on service.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (req_set)  pending <= 1'b1;
        else if (grant)    pending <= 1'b0;
    end

    // Vector register, loaded by a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)        vec_q <= '0;
        else if (cfg_load) vec_q <= cfg_vec;
    end

endmodule

// File: rtl/intr_vec_select.sv
`timescale 1ns/1ps
// AND-OR selector: returns the vector of the granted slot, or zero when none is granted.
// Assumes: grant is one-hot or zero, which the chain guarantees.
module intr_vec_select #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned VEC_W = 8
) (
    input  logic [N_SRC-1:0]       grant,
    input  logic [N_SRC*VEC_W-1:0] vecs,
    output logic [VEC_W-1:0]       sel_vec
);

    // OR together each slot's vector masked by its grant.
    always_comb begin
        sel_vec = '0;
        for (int i = 0; i < N_SRC; i++) begin
            sel_vec |= vecs[i*VEC_W +: VEC_W] & {VEC_W{grant[i]}};
        end
    end

endmodule

// File: rtl/intr_chain_top.sv
`timescale 1ns/1ps
// Interrupt acknowledge chain for N_SRC slots that share one request line.
// Slot 0 is nearest the processor and has the highest priority.
// The response is registered and valid in the cycle after the acknowledge.
// Assumes: ack_pulse is high for a single cycle per acknowledge.
module intr_chain_top #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned VEC_W = 8,
    parameter int unsigned IDX_W = intr_chain_pkg::slot_idx_width(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VEC_W-1:0] cfg_vec,
    input  logic             ack_pulse,
    output logic             irq_line,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             no_source
);

    logic [N_SRC:0]         ack_chain;
    logic [N_SRC-1:0]       grant;
    logic [N_SRC-1:0]       pending;
    logic [N_SRC-1:0]       cfg_load;
    logic [N_SRC*VEC_W-1:0] vecs;
    logic [VEC_W-1:0]       sel_vec;

    assign ack_chain[0] = ack_pulse;

    for (genvar g = 0; g < N_SRC; g++) begin : g_slot
        // Decode the configuration write for this slot.
        assign cfg_load[g] = cfg_we && (cfg_idx == IDX_W'(g));

        intr_chain_cell #(.VEC_W(VEC_W)) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_set  (src_req[g]),
            .cfg_load (cfg_load[g]),
            .cfg_vec  (cfg_vec),
            .ack_in   (ack_chain[g]),
            .ack_out  (ack_chain[g+1]),
            .grant    (grant[g]),
            .pending  (pending[g]),
            .vec_q    (vecs[g*VEC_W +: VEC_W])
        );
    end

    intr_vec_select #(.N_SRC(N_SRC), .VEC_W(VEC_W)) sel_i (
        .grant   (grant),
        .vecs    (vecs),
        .sel_vec (sel_vec)
    );

    // Shared request line: high while any slot is pending.
    assign irq_line = |pending;

    // Register the response; an acknowledge leaving the chain end means no source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
            no_source <= 1'b0;
        end else begin
            vec_valid <= ack_pulse;
            vec_out   <= ack_pulse ? sel_vec : '0;
            no_source <= ack_chain[N_SRC];
        end
    end

endmodule

// File: rtl/intr_chain_chk.sv
`timescale 1ns/1ps
// Property checker for intr_chain_top, attached with bind.
// Assumes: the same parameters as the bound instance.
module intr_chain_chk #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req,
    input logic             ack_pulse,
    input logic             irq_line,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_valid,
    input logic             no_source
);

    assert_req_raises_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> irq_line);

    assert_ack_gives_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> vec_valid);

    assert_strobe_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_pulse));

    assert_empty_ack_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && !irq_line) |=> (no_source && vec_out == '0));

    assert_served_ack_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && irq_line) |=> !no_source);

    assert_idle_outputs_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0 && !no_source));

endmodule

bind intr_chain_top intr_chain_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .ack_pulse (ack_pulse),
    .irq_line  (irq_line),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .no_source (no_source)
);

// File: tb/intr_chain_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for intr_chain_top: drives on falling edges and checks on falling edges.
module intr_chain_top_tb_top;

    localparam int unsigned N_SRC = 8;
    localparam int unsigned VEC_W = 8;
    localparam int unsigned IDX_W = $clog2(N_SRC) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] src_req = '0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [VEC_W-1:0] cfg_vec = '0;
    logic             ack_pulse = 1'b0;
    logic             irq_line;
    logic [VEC_W-1:0] vec_out;
    logic             vec_valid;
    logic             no_source;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intr_chain_top #(.N_SRC(N_SRC), .VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .ack_pulse(ack_pulse),
        .irq_line(irq_line), .vec_out(vec_out), .vec_valid(vec_valid),
        .no_source(no_source)
    );

    function automatic logic [VEC_W-1:0] exp_vec(input int i);
        return VEC_W'(8'hA0 + i);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_vec(input int idx, input logic [VEC_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_vec = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic raise(input logic [N_SRC-1:0] m);
        @(negedge clk);
        src_req = m;
        @(negedge clk);
        src_req = '0;
    endtask

    // Acknowledge, then check the response and its removal a cycle later.
    task automatic do_ack(input string req, input logic [VEC_W-1:0] ev, input logic ens);
        @(negedge clk);
        ack_pulse = 1'b1;
        @(negedge clk);
        ack_pulse = 1'b0;
        check(req, "vec_valid", 32'(vec_valid), 32'd1);
        check(req, "vec_out", 32'(vec_out), 32'(ev));
        check(req, "no_source", 32'(no_source), 32'(ens));
        @(negedge clk);
        check("R6", "vec_valid drop", 32'(vec_valid), 32'd0);
        check("R6", "vec_out idle", 32'(vec_out), 32'd0);
        check("R6", "no_source idle", 32'(no_source), 32'd0);
    endtask

    task automatic t_reset_r1;
        check("R1", "irq_line", 32'(irq_line), 32'd0);
        check("R1", "vec_valid", 32'(vec_valid), 32'd0);
        check("R1", "vec_out", 32'(vec_out), 32'd0);
        check("R1", "no_source", 32'(no_source), 32'd0);
        // Vector registers hold zero: a serviced slot 4 returns 0 with no_source low.
        raise(8'h10);
        do_ack("R1", '0, 1'b0);
    endtask

    task automatic t_config_r7;
        for (int i = 0; i < N_SRC; i++) write_vec(i, exp_vec(i));
        write_vec(N_SRC, 8'hFF);
        write_vec(2 * N_SRC - 1, 8'h5A);
        raise('1);
        for (int i = 0; i < N_SRC; i++) do_ack("R7", exp_vec(i), 1'b0);
    endtask

    task automatic t_line_r2;
        check("R2", "irq idle", 32'(irq_line), 32'd0);
        raise(8'h40);
        check("R2", "irq set", 32'(irq_line), 32'd1);
        do_ack("R2", exp_vec(6), 1'b0);
        check("R2", "irq cleared", 32'(irq_line), 32'd0);
    endtask

    task automatic t_priority_r3_r4;
        raise(8'hA4);
        do_ack("R3", exp_vec(2), 1'b0);
        check("R4", "irq held", 32'(irq_line), 32'd1);
        raise(8'h01);
        do_ack("R3", exp_vec(0), 1'b0);
        do_ack("R4", exp_vec(5), 1'b0);
        check("R4", "irq held last", 32'(irq_line), 32'd1);
        do_ack("R4", exp_vec(7), 1'b0);
        check("R4", "irq dropped", 32'(irq_line), 32'd0);
    endtask

    task automatic t_empty_r5;
        do_ack("R5", '0, 1'b1);
        check("R5", "irq stays low", 32'(irq_line), 32'd0);
    endtask

    task automatic t_collide_r8;
        raise(8'h08);
        @(negedge clk);
        ack_pulse = 1'b1; src_req = 8'h08;
        @(negedge clk);
        ack_pulse = 1'b0; src_req = '0;
        check("R8", "vec_out", 32'(vec_out), 32'(exp_vec(3)));
        check("R8", "irq kept", 32'(irq_line), 32'd1);
        do_ack("R8", exp_vec(3), 1'b0);
        check("R8", "irq cleared", 32'(irq_line), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_config_r7();
        t_line_r2();
        t_priority_r3_r4();
        t_empty_r5();
        t_collide_r8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule